// File: doc/BRIEF.md
# UART Receive Path with Line Status Flags

This block is the receive half of a byte-oriented asynchronous serial port. A serial input is oversampled on a strobe that runs at sixteen times the bit rate. Each completed character is placed in a receive buffer. The buffer is a single holding register when queueing is disabled, and a 16-entry queue when it is enabled. Every queue entry keeps the parity and framing verdict of its own character.

A processor reads received bytes at offset 0 and a status byte at offset 5. The status byte carries four flags:

- data-available;
- lost-character;
- parity-mismatch;
- stop-bit-missing.

A read of the status byte clears the three error flags. The two per-character error flags describe the character at the head of the buffer, not the most recent arrival. The lost-character flag is raised as soon as a character is dropped.

When a stop bit is sampled low, the receiver assumes that this low level is the start bit of the next character. It confirms that assumption with two further samples and then receives the data bits.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset, a read at offset 5 returns 0x00. Status bit layout: bit 0 data-available, bit 1 lost-character, bit 2 parity-mismatch, bit 3 stop-bit-missing; bits 7:4 always read 0.
- R2: A frame consists of a low start bit, 8 data bits LSB first, an optional parity bit and a stop bit, each 16 oversample ticks long. The start bit is accepted only if it is still low at its middle sample. Received bytes are returned at offset 0 in arrival order.
- R3: Status bit 0 is 1 while the holding register (queue disabled) or the queue (queue enabled) holds at least one character. It is 0 once the last character has been read at offset 0. A read at offset 0 while empty returns 0x00.
- R4: A read at offset 5 returns the current flags and clears bits 1, 2 and 3. A flag that is being set in the same cycle stays set.
- R5: With the queue disabled, a character that completes while the holding register is still unread sets bit 1, and the new character replaces the old one.
- R6: With the queue enabled, holding up to 16 characters never sets bit 1. A character that completes while the queue is full sets bit 1 and is discarded, and the 16 stored characters read back unchanged.
- R7: With cfg_par_en=1, a parity bit follows the data. cfg_par_even=1 demands an even number of ones across data and parity, and 0 demands an odd number. A mismatch marks the character with a parity error. With cfg_par_en=0 no parity bit is expected and no parity error is ever flagged.
- R8: A character whose stop bit is sampled low is marked with a framing error.
- R9: With the queue enabled, a character's parity and framing marks are stored with it. They set bits 2 and 3 only when that character becomes the buffer head. A clean head character leaves both bits clear.
- R10: Bit 1 is set in the cycle after the discarded character completes, whatever characters are ahead of it in the buffer.
- R11: After a framing error, the low stop level is taken as a new start bit. The two following samples must both be low, and then data bits are sampled 16, 32, … ticks after the stop sample. If either confirmation sample is high, the receiver returns to idle and delivers no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick | input | 1 | Oversample strobe, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_fifo_en | input | 1 | 1 selects the 16-entry queue, 0 the single holding register |
| cfg_par_en | input | 1 | 1 expects a parity bit after the data |
| cfg_par_even | input | 1 | 1 even parity, 0 odd parity |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_addr | input | 3 | Register offset: 0 received byte, 5 status |
| cpu_rdata | output | 8 | Read data for the addressed offset |

## Verification
The embedded properties check on every cycle that:
- a completed character produces a single-cycle pulse;
- a discard raises the lost-character flag on the next edge and leaves the queue full;
- a status read drops the lost-character flag unless a new loss coincides with it;
- the parity flag can rise only when a new head character is presented;
- reading the last buffered character clears data-available.

Only the bench scenarios can show the arithmetic of the serial format: the bit order and the parity verdict over all 256 byte values, and the per-character error tags surfacing in queue order. The same holds for the exact sample timing of the resynchronising start bit and for the 16/17-character boundary.

// File: rtl/urx_pkg.sv
package urx_pkg;

  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int unsigned ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_RESYNC
  } rx_state_e;

  localparam int unsigned STAT_DR = 0;
  localparam int unsigned STAT_OE = 1;
  localparam int unsigned STAT_PE = 2;
  localparam int unsigned STAT_FE = 3;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd5;

endpackage

// File: rtl/urx_shifter.sv
module urx_shifter
  import urx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      par_en,
  input  logic      par_even,
  output logic      ch_valid,
  output rx_entry_t ch_out
);

  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT   = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] SEED_CNT  = CNT_W'(2);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

  logic              rx_meta, rx_s;
  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  logic              vld_q, vld_d;
  rx_entry_t         out_q, out_d;

  // two-flop input synchroniser, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rx_s    <= rx_meta;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    pbit_d  = pbit_q;
    out_d   = out_q;
    vld_d   = 1'b0;
    if (tick) begin
      case (state_q)
        RX_IDLE: begin
          if (!rx_s) begin
            state_d = RX_START;
            cnt_d   = CNT_W'(1);
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d = '0;
            bit_d = '0;
            state_d = rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
            sh_d  = {rx_s, sh_q[DATA_W-1:1]};
            if (bit_q == LAST_BIT) begin
              state_d = par_en ? RX_PAR : RX_STOP;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            pbit_d  = rx_s;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST_CNT) begin
            vld_d      = 1'b1;
            out_d.data = sh_q;
            out_d.ferr = ~rx_s;
            out_d.perr = par_en & ((^sh_q ^ pbit_q) == par_even);
            cnt_d      = '0;
            state_d    = rx_s ? RX_IDLE : RX_RESYNC;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_RESYNC: begin
          // stop-position low is treated as the next start bit: confirm twice
          if (rx_s) begin
            state_d = RX_IDLE;
          end else if (cnt_q == CNT_W'(1)) begin
            state_d = RX_DATA;
            cnt_d   = SEED_CNT;
            bit_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      vld_q   <= 1'b0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
      vld_q   <= vld_d;
      if (vld_d) out_q <= out_d;
    end
  end

  assign ch_valid = vld_q;
  assign ch_out   = out_q;

  // R2
  ch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |=> !ch_valid);

  // R8
  good_stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && !ch_out.ferr) |-> (state_q == RX_IDLE));

  // R11
  resync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_RESYNC && tick && rx_s) |=> (state_q == RX_IDLE));

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           wdata,
  output logic [WIDTH-1:0]           rdata,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == PTR_MAX) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == PTR_MAX) ? '0 : rptr_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);
  assign count = cnt_q;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/urx_status.sv
module urx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic head_new,
  input  logic head_valid,
  input  logic head_perr,
  input  logic head_ferr,
  input  logic stat_rd,
  output logic oe,
  output logic pe,
  output logic fe
);

  logic oe_q, oe_d, pe_q, pe_d, fe_q, fe_d;
  logic pe_set, fe_set;

  always_comb begin
    pe_set = head_new & head_valid & head_perr;
    fe_set = head_new & head_valid & head_ferr;
    oe_d   = ovr_evt | (oe_q & ~stat_rd);
    pe_d   = pe_set  | (pe_q & ~stat_rd);
    fe_d   = fe_set  | (fe_q & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      pe_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
      pe_q <= pe_d;
      fe_q <= fe_d;
    end
  end

  assign oe = oe_q;
  assign pe = pe_q;
  assign fe = fe_q;

  // R4
  oe_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt) |=> !oe_q);

  // R4
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !stat_rd) |=> oe_q);

  // R9
  pe_head_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_new && !pe_q) |=> !pe_q);

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import urx_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       cfg_fifo_en,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cpu_rd,
  input  logic [2:0] cpu_addr,
  output logic [7:0] cpu_rdata
);

  localparam int unsigned FCNT_W = $clog2(FIFO_DEPTH + 1);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              ch_valid;
  rx_entry_t         ch_out;
  logic              stat_rd, data_rd;
  logic              f_push, f_pop, f_empty, f_full, f_ovr, f_head_new;
  logic [ENTRY_W-1:0] f_rdata;
  logic [FCNT_W-1:0] f_count;
  rx_entry_t         hold_q, hold_d;
  logic              hold_vld_q, hold_vld_d, hold_ld, hold_ovr;
  rx_entry_t         head;
  logic              head_valid, head_new_d, head_new_q;
  logic              oe, pe, fe;
  logic [7:0]        stat_byte;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  urx_shifter #(.OSR(OSR)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (os_tick),
    .rxd      (rxd),
    .par_en   (cfg_par_en),
    .par_even (cfg_par_even),
    .ch_valid (ch_valid),
    .ch_out   (ch_out)
  );

  assign stat_rd = cpu_rd & (cpu_addr == OFS_STAT);
  assign data_rd = cpu_rd & (cpu_addr == OFS_DATA);

  // queued path
  always_comb begin
    f_pop      = cfg_fifo_en & data_rd & ~f_empty;
    f_push     = cfg_fifo_en & ch_valid & (~f_full | f_pop);
    f_ovr      = cfg_fifo_en & ch_valid & f_full & ~f_pop;
    f_head_new = (f_push & f_empty) |
                 (f_pop & ((f_count > FCNT_W'(1)) | f_push));
  end

  urx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_core_n),
    .push  (f_push),
    .pop   (f_pop),
    .wdata (ch_out),
    .rdata (f_rdata),
    .empty (f_empty),
    .full  (f_full),
    .count (f_count)
  );

  // single holding register path
  always_comb begin
    hold_ld    = ~cfg_fifo_en & ch_valid;
    hold_ovr   = hold_ld & hold_vld_q & ~data_rd;
    hold_d     = hold_ld ? ch_out : hold_q;
    hold_vld_d = hold_ld | (hold_vld_q & ~(data_rd & ~cfg_fifo_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      head_new_q <= 1'b0;
    end else if (!rst_core_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      head_new_q <= 1'b0;
    end else begin
      hold_vld_q <= hold_vld_d;
      head_new_q <= head_new_d;
      if (hold_ld) hold_q <= hold_d;
    end
  end

  // head-of-buffer selection
  always_comb begin
    head       = cfg_fifo_en ? rx_entry_t'(f_rdata) : hold_q;
    head_valid = cfg_fifo_en ? ~f_empty : hold_vld_q;
    head_new_d = cfg_fifo_en ? f_head_new : hold_ld;
  end

  urx_status u_status (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ovr_evt    (f_ovr | hold_ovr),
    .head_new   (head_new_q),
    .head_valid (head_valid),
    .head_perr  (head.perr),
    .head_ferr  (head.ferr),
    .stat_rd    (stat_rd),
    .oe         (oe),
    .pe         (pe),
    .fe         (fe)
  );

  always_comb begin
    stat_byte          = '0;
    stat_byte[STAT_DR] = head_valid;
    stat_byte[STAT_OE] = oe;
    stat_byte[STAT_PE] = pe;
    stat_byte[STAT_FE] = fe;
    case (cpu_addr)
      OFS_DATA: cpu_rdata = head_valid ? head.data : 8'h00;
      OFS_STAT: cpu_rdata = stat_byte;
      default:  cpu_rdata = 8'h00;
    endcase
  end

  // R10
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (f_ovr || hold_ovr) |=> oe);

  // R6
  ovr_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    f_ovr |=> f_full);

  // R5
  hold_replace_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    hold_ovr |=> (hold_vld_q && hold_q == $past(ch_out)));

  // R3
  dr_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (data_rd && head_valid && !ch_valid &&
     (!cfg_fifo_en || f_count == FCNT_W'(1))) |=> !head_valid);

endmodule

// File: tb/uart_rx_lsr_tb.sv
`timescale 1ns/1ps
module uart_rx_lsr_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rxd;
  logic       cfg_fifo_en, cfg_par_en, cfg_par_even;
  logic       cpu_rd;
  logic [2:0] cpu_addr;
  logic [7:0] cpu_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_lsr u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .os_tick      (os_tick),
    .rxd          (rxd),
    .cfg_fifo_en  (cfg_fifo_en),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_even (cfg_par_even),
    .cpu_rd       (cpu_rd),
    .cpu_addr     (cpu_addr),
    .cpu_rdata    (cpu_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic fifo, input logic pen, input logic peven);
    @(negedge clk);
    rst_n = 1'b0; rxd = 1'b1; cpu_rd = 1'b0; cpu_addr = 3'd0;
    cfg_fifo_en = fifo; cfg_par_en = pen; cfg_par_even = peven;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hold_bit(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  // stop_ok=0: stop low for half a bit then high (resync aborts)
  task automatic send_frame(input logic [7:0] d, input logic with_par,
                            input logic pbit, input logic stop_ok);
    hold_bit(1'b0, 16);
    for (int i = 0; i < 8; i++) hold_bit(d[i], 16);
    if (with_par) hold_bit(pbit, 16);
    if (stop_ok) hold_bit(1'b1, 16);
    else begin
      hold_bit(1'b0, 8);
      hold_bit(1'b1, 8);
    end
    hold_bit(1'b1, 16);
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
    cpu_addr = a;
    cpu_rd   = 1'b1;
    #1;
    d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] stat(input logic dr, input logic oe,
                                      input logic pe, input logic fe);
    return {4'b0000, fe, pe, oe, dr};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    os_tick = 1'b1;
    rst_n = 1'b0; rxd = 1'b1; cpu_rd = 1'b0; cpu_addr = 3'd0;
    cfg_fifo_en = 1'b0; cfg_par_en = 1'b1; cfg_par_even = 1'b1;

    // R1 reset state, R3 empty read
    do_reset(1'b0, 1'b1, 1'b1);
    cpu_read(3'd5, rd); check("R1 status after reset", rd, 8'h00);
    cpu_read(3'd0, rd); check("R3 data read while empty", rd, 8'h00);

    // R2 R7 sweep of all byte values with parity, both senses, injected errors
    for (int v = 0; v < 256; v++) begin
      logic even, bad, pbit;
      even = v[1];
      bad  = (v % 5) == 0;
      pbit = (even ? ^v[7:0] : ~^v[7:0]) ^ bad;
      cfg_par_even = even;
      send_frame(v[7:0], 1'b1, pbit, 1'b1);
      cpu_read(3'd5, rd); check("R7 parity verdict in status", rd, stat(1'b1, 1'b0, bad, 1'b0));
      cpu_read(3'd0, rd); check("R2 received byte", rd, v[7:0]);
      cpu_read(3'd5, rd); check("R4 R3 status cleared and empty", rd, 8'h00);
    end

    // R7 parity disabled: no parity bit, never a parity error
    cfg_par_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 17 + 3);
      send_frame(v, 1'b0, 1'b0, 1'b1);
      cpu_read(3'd5, rd); check("R7 no parity status", rd, 8'h01);
      cpu_read(3'd0, rd); check("R7 byte without parity", rd, v);
    end

    // R8 framing error; R11 resync abort delivers nothing more
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
    cpu_read(3'd5, rd); check("R8 framing flag", rd, 8'h09);
    cpu_read(3'd0, rd); check("R8 byte with bad stop", rd, 8'h5A);
    cpu_read(3'd5, rd); check("R11 abort gives no extra char", rd, 8'h00);

    // R5 overrun of the holding register
    send_frame(8'h11, 1'b0, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b0, 1'b1);
    cpu_read(3'd5, rd); check("R5 overrun flag", rd, 8'h03);
    cpu_read(3'd0, rd); check("R5 newest byte kept", rd, 8'h22);
    cpu_read(3'd5, rd); check("R4 overrun cleared", rd, 8'h00);

    // R11 resync: stop-position low becomes next start bit
    do_reset(1'b1, 1'b0, 1'b1);
    hold_bit(1'b0, 16);
    for (int i = 0; i < 8; i++) hold_bit(8'hC3 >> i, 16);
    hold_bit(1'b0, 16);
    for (int i = 0; i < 8; i++) hold_bit(8'h3C >> i, 16);
    hold_bit(1'b1, 16);
    hold_bit(1'b1, 16);
    cpu_read(3'd5, rd); check("R11 first char framing", rd, 8'h09);
    cpu_read(3'd0, rd); check("R11 first char", rd, 8'hC3);
    cpu_read(3'd5, rd); check("R11 resynced char clean", rd, 8'h01);
    cpu_read(3'd0, rd); check("R11 resynced char data", rd, 8'h3C);
    cpu_read(3'd5, rd); check("R3 empty after resync chars", rd, 8'h00);

    // R9 per-character error tags surface at the head
    do_reset(1'b1, 1'b1, 1'b1);
    send_frame(8'h31, 1'b1, ^8'h31, 1'b1);
    send_frame(8'h42, 1'b1, ~^8'h42, 1'b1);
    send_frame(8'h53, 1'b1, ^8'h53, 1'b1);
    send_frame(8'h64, 1'b1, ^8'h64, 1'b0);
    cpu_read(3'd5, rd); check("R9 clean head hides later errors", rd, 8'h01);
    cpu_read(3'd0, rd); check("R9 head A", rd, 8'h31);
    cpu_read(3'd5, rd); check("R9 parity tag at head", rd, 8'h05);
    cpu_read(3'd0, rd); check("R9 head B", rd, 8'h42);
    cpu_read(3'd5, rd); check("R9 clean head C", rd, 8'h01);
    cpu_read(3'd0, rd); check("R9 head C", rd, 8'h53);
    cpu_read(3'd5, rd); check("R9 framing tag at head", rd, 8'h09);
    cpu_read(3'd0, rd); check("R9 head D", rd, 8'h64);
    cpu_read(3'd5, rd); check("R3 queue drained", rd, 8'h00);

    // R6 R10 queue full boundary
    do_reset(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 16; i++) send_frame(8'(i * 13 + 7), 1'b0, 1'b0, 1'b1);
    cpu_read(3'd5, rd); check("R6 full queue no overrun", rd, 8'h01);
    send_frame(8'hEE, 1'b0, 1'b0, 1'b1);
    cpu_read(3'd5, rd); check("R6 R10 overrun shown immediately", rd, 8'h03);
    cpu_read(3'd5, rd); check("R4 overrun cleared by read", rd, 8'h01);
    for (int i = 0; i < 16; i++) begin
      cpu_read(3'd0, rd); check("R6 stored char intact", rd, 8'(i * 13 + 7));
    end
    cpu_read(3'd5, rd); check("R6 R3 discarded char absent", rd, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule